// File: doc/BRIEF.md
# Receive DMA Descriptor Engine

This block runs the link-to-host receive direction of a DMA. Software programs the location of a descriptor through a small register port and then issues a run command. The engine sends one upstream read for the descriptor and collects the completion bytes. The descriptor gives a destination address and a buffer length. The engine then takes bytes from a receive stream. Each byte is marked by a data-valid strobe, and a packet is a run of consecutive valid bytes.

Accepted bytes go to host memory as upstream posted writes. No write carries more payload than a set limit, and a packet end also closes a write. Bytes beyond the buffer length are dropped, and an overflow flag records the loss. Once the buffer is full and the current packet has ended, the engine writes a status word back next to the descriptor. It then sends an interrupt message and returns to idle.

All upstream traffic leaves on one byte-wide request channel with a valid/ready handshake. The first beat of a request carries its header. Completion bytes and receive bytes arrive with no back-pressure.

Top module: `rxdma_rx_engine`

## Requirements
- R1: After reset the engine is idle: `req_valid` is 0 and a read of register 0 returns 0 (busy bit 0 clear).
- R2: A read request returns data one cycle later with `reg_rvalid` high for exactly that cycle. Register 1 holds descriptor address bits 31:0, register 2 holds bits 63:32, and register 0 bit 0 reads 1 while a descriptor is in progress.
- R3: Writing 1 to register 0 bit 0 while idle produces exactly one read request as one beat. That beat has kind 0, both start and end flags set, the descriptor address, and length 10 (8 address bytes plus the length field in bytes).
- R4: Completion bytes are taken in arrival order. Bytes 0 to 7 form the destination address, least significant byte first. The next bytes form the buffer length, also least significant byte first.
- R5: Receive bytes presented while idle or before the last descriptor byte has arrived are never written to memory.
- R6: Accepted bytes leave as write requests of kind 1 to consecutive addresses starting at the destination, one byte per beat, in arrival order. The header on every beat gives the write's base address and its payload length. A write closes after MAX_PL bytes or at the end of a packet, whichever comes first. Its first beat has the start flag set and its last beat has the end flag set.
- R7: A cycle with `rx_sync` high adds no byte and ends a packet. If it arrives before the descriptor completes, it sets bit 17 of the status word.
- R8: Bytes arriving when the buffer is already full are dropped, and bit 16 of the status word is set.
- R9: The descriptor completes at the first cycle with no valid byte after the remaining length has reached 0. The engine then issues a 4-byte write of kind 1 to the descriptor address plus DONE_OFS, carrying the status word least significant byte first. Bits 15:0 of the status word give the number of bytes written.
- R10: The status write starts only after the last data write has been accepted. One message beat of kind 2 follows it, with both flags set and data MSG_CODE, and the engine is then idle.
- R11: A buffer length of 0 completes with no data writes and a byte count of 0.
- R12: While the engine is busy, writes to registers 0 to 2 have no effect.
- R13: While `req_valid` is high and `req_ready` is low, every request output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| req_valid | output | 1 | Upstream request beat valid |
| req_ready | input | 1 | Upstream request beat accepted |
| req_kind | output | 2 | 0 read, 1 posted write, 2 message |
| req_sop | output | 1 | First beat of a request |
| req_eop | output | 1 | Last beat of a request |
| req_addr | output | 64 | Request base address |
| req_len | output | LEN_W | Request payload length in bytes |
| req_data | output | 8 | Payload byte |
| cpl_valid | input | 1 | Completion byte valid |
| cpl_data | input | 8 | Completion byte |
| rx_dav | input | 1 | Receive byte valid |
| rx_sync | input | 1 | Sync/trigger pulse |
| rx_data | input | 8 | Receive byte |

## Verification
The bench builds the engine with MAX_PL of 4, a 16-bit length field, a 64-byte data store and a 32-entry chunk queue. With 4-byte writes, the 15-byte packet sequence crosses chunk boundaries, packet-end flushes and packet boundaries. Sweeping the buffer length from 0 to 15 then places truncation at every byte position, including the exact-fill and empty-buffer cases. Alternate runs throttle `req_ready` and add a sync cycle inside a packet gap. Whether that sync counts depends on whether the buffer filled in the first packet.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [1:0] {
    REQ_MRD = 2'd0,
    REQ_MWR = 2'd1,
    REQ_MSG = 2'd2
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DESC,
    ST_RECV,
    ST_DONE,
    ST_IRQ
  } eng_state_e;

  localparam int ADDR_BYTES = 8;

endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign push_ok = push && (cnt != (AW+1)'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxdma_rx_front.sv
module rxdma_rx_front #(
  parameter int LEN_W  = 16,
  parameter int MAX_PL = 128,
  localparam int CW    = $clog2(MAX_PL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [LEN_W-1:0] arm_len,
  input  logic             active,
  input  logic             rx_dav,
  input  logic             rx_sync,
  input  logic [7:0]       rx_data,
  output logic             byte_push,
  output logic [7:0]       byte_out,
  output logic             chunk_push,
  output logic [CW-1:0]    chunk_len,
  output logic             fin,
  output logic [LEN_W-1:0] total,
  output logic             ovf,
  output logic             sync_seen
);
  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    fill;
  logic             in_pkt;
  logic             byte_ok, live, full_chunk, end_chunk;

  assign byte_ok    = rx_dav && !rx_sync;
  assign live       = active && !fin;
  assign byte_push  = live && byte_ok && (remain != '0);
  assign byte_out   = rx_data;
  assign full_chunk = byte_push && (fill == CW'(MAX_PL - 1));
  assign end_chunk  = live && !byte_ok && in_pkt && (fill != '0);
  assign chunk_push = full_chunk || end_chunk;
  assign chunk_len  = full_chunk ? CW'(MAX_PL) : fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      fill      <= '0;
      in_pkt    <= 1'b0;
      fin       <= 1'b0;
      total     <= '0;
      ovf       <= 1'b0;
      sync_seen <= 1'b0;
    end else if (arm) begin
      remain    <= arm_len;
      fill      <= '0;
      in_pkt    <= 1'b0;
      fin       <= 1'b0;
      total     <= '0;
      ovf       <= 1'b0;
      sync_seen <= 1'b0;
    end else if (live) begin
      if (rx_sync) sync_seen <= 1'b1;
      if (byte_ok) begin
        in_pkt <= 1'b1;
        if (remain != '0) begin
          remain <= remain - LEN_W'(1);
          total  <= total + LEN_W'(1);
          fill   <= full_chunk ? '0 : fill + CW'(1);
        end else begin
          ovf <= 1'b1;
        end
      end else begin
        in_pkt <= 1'b0;
        fill   <= '0;
        if (remain == '0) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxdma_rx_engine.sv
module rxdma_rx_engine
  import rxdma_pkg::*;
#(
  parameter int         LEN_W       = 16,
  parameter int         MAX_PL      = 128,
  parameter int         DATA_DEPTH  = 512,
  parameter int         CHUNK_DEPTH = 16,
  parameter int         DONE_OFS    = 16,
  parameter logic [7:0] MSG_CODE    = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [1:0]       req_kind,
  output logic             req_sop,
  output logic             req_eop,
  output logic [63:0]      req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic [7:0]       req_data,
  input  logic             cpl_valid,
  input  logic [7:0]       cpl_data,
  input  logic             rx_dav,
  input  logic             rx_sync,
  input  logic [7:0]       rx_data
);
  localparam int CW         = $clog2(MAX_PL + 1);
  localparam int DESC_BYTES = ADDR_BYTES + LEN_W / 8;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int DCW        = $clog2(DESC_BYTES);
  localparam int STAT_BYTES = ((LEN_W + 2 + 31) / 32) * 4;
  localparam int STAT_W     = STAT_BYTES * 8;
  localparam int SCW        = $clog2(STAT_BYTES);

  eng_state_e        state;
  logic [63:0]       desc_addr;
  logic [DESC_W-1:0] desc_sr;
  logic [DCW-1:0]    desc_cnt;
  logic              arm_q;
  logic [63:0]       wr_addr;
  logic [CW-1:0]     wr_cnt;
  logic [SCW-1:0]    st_cnt;

  logic              byte_push, chunk_push, fin, ovf, sync_seen;
  logic [7:0]        byte_in;
  logic [CW-1:0]     chunk_in;
  logic [LEN_W-1:0]  total;
  logic [7:0]        data_head;
  logic [CW-1:0]     len_head;
  logic              data_empty, len_empty;

  logic [63:0]       dest;
  logic [LEN_W-1:0]  blen;
  logic [STAT_W-1:0] status;
  logic              req_fire, wr_eop, data_pop, len_pop, busy;

  assign dest     = desc_sr[63:0];
  assign blen     = desc_sr[64 +: LEN_W];
  assign status   = STAT_W'({sync_seen, ovf, total});
  assign busy     = (state != ST_IDLE);
  assign req_fire = req_valid && req_ready;
  assign wr_eop   = (wr_cnt == len_head - CW'(1));
  assign data_pop = (state == ST_RECV) && req_fire;
  assign len_pop  = data_pop && wr_eop;

  rxdma_rx_front #(.LEN_W(LEN_W), .MAX_PL(MAX_PL)) u_front (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm_q),
    .arm_len   (blen),
    .active    (state == ST_RECV),
    .rx_dav    (rx_dav),
    .rx_sync   (rx_sync),
    .rx_data   (rx_data),
    .byte_push (byte_push),
    .byte_out  (byte_in),
    .chunk_push(chunk_push),
    .chunk_len (chunk_in),
    .fin       (fin),
    .total     (total),
    .ovf       (ovf),
    .sync_seen (sync_seen)
  );

  rxdma_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk  (clk),
    .rst  (rst),
    .push (byte_push),
    .din  (byte_in),
    .pop  (data_pop),
    .dout (data_head),
    .empty(data_empty)
  );

  rxdma_fifo #(.W(CW), .DEPTH(CHUNK_DEPTH)) u_chunk_q (
    .clk  (clk),
    .rst  (rst),
    .push (chunk_push),
    .din  (chunk_in),
    .pop  (len_pop),
    .dout (len_head),
    .empty(len_empty)
  );

  always_comb begin
    req_valid = 1'b0;
    req_kind  = REQ_MWR;
    req_sop   = 1'b0;
    req_eop   = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    req_data  = '0;
    unique case (state)
      ST_FETCH: begin
        req_valid = 1'b1;
        req_kind  = REQ_MRD;
        req_sop   = 1'b1;
        req_eop   = 1'b1;
        req_addr  = desc_addr;
        req_len   = LEN_W'(DESC_BYTES);
      end
      ST_RECV: begin
        req_valid = !len_empty && !data_empty;
        req_sop   = (wr_cnt == '0);
        req_eop   = wr_eop;
        req_addr  = wr_addr;
        req_len   = LEN_W'(len_head);
        req_data  = data_head;
      end
      ST_DONE: begin
        req_valid = 1'b1;
        req_sop   = (st_cnt == '0);
        req_eop   = (st_cnt == SCW'(STAT_BYTES - 1));
        req_addr  = desc_addr + 64'(DONE_OFS);
        req_len   = LEN_W'(STAT_BYTES);
        req_data  = status[st_cnt * 8 +: 8];
      end
      ST_IRQ: begin
        req_valid = 1'b1;
        req_kind  = REQ_MSG;
        req_sop   = 1'b1;
        req_eop   = 1'b1;
        req_data  = MSG_CODE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      desc_addr  <= '0;
      desc_sr    <= '0;
      desc_cnt   <= '0;
      arm_q      <= 1'b0;
      wr_addr    <= '0;
      wr_cnt     <= '0;
      st_cnt     <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      arm_q      <= 1'b0;
      reg_rvalid <= reg_rd;
      case (reg_addr)
        2'd0:    reg_rdata <= {31'b0, busy};
        2'd1:    reg_rdata <= desc_addr[31:0];
        2'd2:    reg_rdata <= desc_addr[63:32];
        default: reg_rdata <= '0;
      endcase
      if (reg_wr && !busy) begin
        if (reg_addr == 2'd1) desc_addr[31:0]  <= reg_wdata;
        if (reg_addr == 2'd2) desc_addr[63:32] <= reg_wdata;
      end
      unique case (state)
        ST_IDLE: begin
          if (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (req_ready) begin
            state    <= ST_DESC;
            desc_cnt <= '0;
          end
        end
        ST_DESC: begin
          if (cpl_valid) begin
            desc_sr <= {cpl_data, desc_sr[DESC_W-1:8]};
            if (desc_cnt == DCW'(DESC_BYTES - 1)) begin
              state <= ST_RECV;
              arm_q <= 1'b1;
            end else begin
              desc_cnt <= desc_cnt + DCW'(1);
            end
          end
        end
        ST_RECV: begin
          if (arm_q) begin
            wr_addr <= dest;
            wr_cnt  <= '0;
          end else begin
            if (req_fire) begin
              if (wr_eop) begin
                wr_cnt  <= '0;
                wr_addr <= wr_addr + 64'(len_head);
              end else begin
                wr_cnt <= wr_cnt + CW'(1);
              end
            end
            if (fin && len_empty) begin
              state  <= ST_DONE;
              st_cnt <= '0;
            end
          end
        end
        ST_DONE: begin
          if (req_ready) begin
            if (st_cnt == SCW'(STAT_BYTES - 1)) state <= ST_IRQ;
            else st_cnt <= st_cnt + SCW'(1);
          end
        end
        ST_IRQ: begin
          if (req_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdma_rx_engine_chk.sv
module rxdma_rx_engine_chk #(
  parameter int         LEN_W    = 16,
  parameter int         MAX_PL   = 128,
  parameter logic [7:0] MSG_CODE = 8'h20
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_kind,
  input logic             req_sop,
  input logic             req_eop,
  input logic [63:0]      req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic [7:0]       req_data
);
  localparam int DESC_BYTES = 8 + LEN_W / 8;
  localparam int STAT_BYTES = ((LEN_W + 2 + 31) / 32) * 4;
  localparam int LEN_LIM    = (MAX_PL > STAT_BYTES) ? MAX_PL : STAT_BYTES;

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  assert_rvalid_single_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);

  assert_fetch_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0) |-> (req_sop && req_eop && req_len == LEN_W'(DESC_BYTES)));

  assert_write_len_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1) |-> (req_len != '0 && req_len <= LEN_W'(LEN_LIM)));

  assert_next_sop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_eop) |=> (!req_valid || req_sop));

  assert_msg_beat_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd2) |-> (req_sop && req_eop && req_data == MSG_CODE));

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_sop) &&
      $stable(req_eop) && $stable(req_addr) && $stable(req_len) && $stable(req_data)));
endmodule

bind rxdma_rx_engine rxdma_rx_engine_chk #(
  .LEN_W(LEN_W), .MAX_PL(MAX_PL), .MSG_CODE(MSG_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd),
  .reg_rvalid(reg_rvalid),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_sop   (req_sop),
  .req_eop   (req_eop),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .req_data  (req_data)
);

// File: tb/tb_rxdma_rx_engine.sv
module tb_rxdma_rx_engine;
  localparam int         MAXP  = 4;
  localparam int         DONEO = 16;
  localparam logic [7:0] MCODE = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        req_valid, req_ready = 1'b1;
  logic [1:0]  req_kind;
  logic        req_sop, req_eop;
  logic [63:0] req_addr;
  logic [15:0] req_len;
  logic [7:0]  req_data;
  logic        cpl_valid = 1'b0;
  logic [7:0]  cpl_data = '0;
  logic        rx_dav = 1'b0, rx_sync = 1'b0;
  logic [7:0]  rx_data = '0;

  always #2 clk = ~clk;

  rxdma_rx_engine #(
    .LEN_W(16), .MAX_PL(MAXP), .DATA_DEPTH(64), .CHUNK_DEPTH(32),
    .DONE_OFS(DONEO), .MSG_CODE(MCODE)
  ) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_sop(req_sop), .req_eop(req_eop), .req_addr(req_addr), .req_len(req_len),
    .req_data(req_data), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .rx_dav(rx_dav), .rx_sync(rx_sync), .rx_data(rx_data)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit ready_mode = 1'b0;
  bit finished = 1'b0;

  logic [1:0]  lk [512];
  logic        ls [512], le [512];
  logic [63:0] la [512];
  logic [15:0] ll [512];
  logic [7:0]  ld [512];
  int          ln = 0;
  bit          msg_seen = 1'b0;
  int          hold_err = 0;
  bit          hv = 1'b0;
  logic [1:0]  hk;
  logic        hs, he;
  logic [63:0] ha;
  logic [15:0] hl;
  logic [7:0]  hd;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    req_ready = ready_mode ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (hv && !(req_valid && req_kind == hk && req_sop == hs && req_eop == he &&
                  req_addr == ha && req_len == hl && req_data == hd))
        hold_err++;
      hv = req_valid && !req_ready;
      hk = req_kind; hs = req_sop; he = req_eop; ha = req_addr; hl = req_len; hd = req_data;
      if (req_valid && req_ready && ln < 512) begin
        lk[ln] = req_kind; ls[ln] = req_sop; le[ln] = req_eop;
        la[ln] = req_addr; ll[ln] = req_len; ld[ln] = req_data;
        if (req_kind == 2'd2) msg_seen = 1'b1;
        ln++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] d, output bit v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic rx_cycle(input bit dav, input bit syn, input logic [7:0] d);
    @(negedge clk);
    rx_dav = dav; rx_sync = syn; rx_data = d;
  endtask

  function automatic logic [7:0] val(input int r, input int i);
    return 8'((r * 29 + i * 7 + 3) & 255);
  endfunction

  task automatic run_one(input int r);
    int blen = r;
    logic [63:0] desc = 64'h0000_0002_0000_0000 + 64'(r) * 64'h100;
    logic [63:0] dest = 64'hA1B2_C3D4_0000_0000 + 64'(r) * 64'h1000 + 64'h35;
    int plen [3] = '{5, 7, 3};
    logic [7:0] expb [64];
    int clen [32];
    int na = 0, nc = 0, fill = 0, rem, idx = 0, pos, err6 = 0, base;
    bit fin_m, ovf_m = 1'b0, syn_m;
    logic [31:0] st, rd;
    bit rv, ok;

    ready_mode = r[1];
    do_write(2'd1, desc[31:0]);
    do_write(2'd2, desc[63:32]);
    if (r == 0) begin
      do_read(2'd1, rd, rv);
      check(rv && rd == desc[31:0], "R2", "desc lo readback", rd, desc[31:0]);
      do_read(2'd2, rd, rv);
      check(rv && rd == desc[63:32], "R2", "desc hi readback", rd, desc[63:32]);
    end
    // R5: bytes while idle must not reach memory
    for (int k = 0; k < 3; k++) rx_cycle(1'b1, 1'b0, 8'hC0 + 8'(k));
    rx_cycle(1'b0, 1'b0, 8'h00);
    ln = 0; msg_seen = 1'b0; hold_err = 0;
    do_write(2'd0, 32'h1);
    for (int k = 0; k < 50 && ln == 0; k++) @(negedge clk);
    check(ln >= 1 && lk[0] == 2'd0 && ls[0] && le[0] && la[0] == desc && ll[0] == 16'd10,
          "R3", "descriptor read beat", la[0], desc);
    if (r == 3) begin
      do_read(2'd0, rd, rv);
      check(rd == 32'h1, "R2", "busy bit during run", rd, 1);
      do_write(2'd1, 32'hDEAD_0000);
      do_write(2'd0, 32'h1);
      do_read(2'd1, rd, rv);
      check(rd == desc[31:0], "R12", "desc lo write while busy", rd, desc[31:0]);
    end
    // R5: bytes before the descriptor completes
    rx_cycle(1'b1, 1'b0, 8'hBB);
    rx_cycle(1'b1, 1'b0, 8'hBC);
    rx_cycle(1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cpl_valid = 1'b1;
      cpl_data = (k < 8) ? dest[k*8 +: 8] : 8'(blen >> ((k - 8) * 8));
    end
    @(negedge clk);
    cpl_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      for (int j = 0; j < plen[p]; j++) rx_cycle(1'b1, 1'b0, val(r, idx + j));
      idx += plen[p];
      if (p == 1 && r[0]) rx_cycle(1'b1, 1'b1, 8'hEE);
      else rx_cycle(1'b0, 1'b0, 8'h00);
      rx_cycle(1'b0, 1'b0, 8'h00);
    end
    for (int k = 0; k < 2000 && !msg_seen; k++) @(negedge clk);
    repeat (2) @(negedge clk);

    rem = blen; fin_m = (blen == 0); idx = 0;
    for (int p = 0; p < 3; p++) begin
      if (!fin_m) begin
        for (int j = 0; j < plen[p]; j++) begin
          if (rem > 0) begin
            expb[na++] = val(r, idx + j); rem--; fill++;
            if (fill == MAXP) begin clen[nc++] = fill; fill = 0; end
          end else ovf_m = 1'b1;
        end
        if (fill != 0) begin clen[nc++] = fill; fill = 0; end
        if (rem == 0) fin_m = 1'b1;
      end
      idx += plen[p];
    end
    syn_m = r[0] && (blen > 5);

    pos = 1; base = 0;
    for (int c = 0; c < nc; c++) begin
      for (int b = 0; b < clen[c]; b++) begin
        if (!(pos < ln && lk[pos] == 2'd1 && la[pos] == dest + 64'(base) &&
              ll[pos] == 16'(clen[c]) && ls[pos] == (b == 0) &&
              le[pos] == (b == clen[c] - 1) && ld[pos] == expb[base + b]))
          err6++;
        pos++;
      end
      base += clen[c];
    end
    check(err6 == 0, "R6", "data write beats mismatching", err6, 0);
    if (na > 0)
      check(la[1] == dest, "R4", "first write address", la[1], dest);
    if (blen == 0)
      check(ln == 6 && lk[1] == 2'd1 && ll[1] == 16'd4, "R11", "beats for empty buffer", ln, 6);
    ok = 1'b1;
    for (int b = 0; b < 4; b++) begin
      if (!(pos + b < ln && lk[pos+b] == 2'd1 && la[pos+b] == desc + 64'(DONEO) &&
            ll[pos+b] == 16'd4 && ls[pos+b] == (b == 0) && le[pos+b] == (b == 3)))
        ok = 1'b0;
      st[b*8 +: 8] = ld[pos+b];
    end
    check(ok, "R9", "status write framing", la[pos], desc + 64'(DONEO));
    check(st[15:0] == 16'(na), "R9", "bytes written", st[15:0], na);
    check(st[16] == ovf_m, "R8", "overflow bit", st[16], ovf_m);
    check(st[17] == syn_m, "R7", "sync bit", st[17], syn_m);
    check(ln == na + 6 && lk[pos+4] == 2'd2 && ls[pos+4] && le[pos+4] && ld[pos+4] == MCODE,
          "R10", "message after status write", ld[pos+4], MCODE);
    if (ready_mode)
      check(hold_err == 0, "R13", "outputs changed while stalled", hold_err, 0);
  endtask

  initial begin
    logic [31:0] rd;
    bit rv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
    do_read(2'd0, rd, rv);
    check(rv && rd == 32'h0, "R1", "control read after reset", rd, 0);
    for (int r = 0; r < 16; r++) run_one(r);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule